// File: doc/BRIEF.md
# Nested Internal Interrupt Controller

This block gathers fifteen on-chip interrupt sources that share a single processor interrupt level. Each source raises a one-cycle event strobe. The block keeps a pending bit, a mask bit and an in-service bit for every source. It raises one request level toward the host processor for the most urgent source that is allowed to interrupt. When the processor acknowledges, the block supplies that source's vector number.

Priority among sources is fixed by source number: source 15 is the most urgent and source 1 the least. An acknowledge moves the presented source from pending to in-service. While a source is in service, it holds off every source at its own number or below. Sources above it can still interrupt, so service routines nest inside the single processor level. Software releases a source by writing a 1 to its in-service bit. Software also programs the mask and the upper bits of the vector through a small write port.

Top module: `nic_top`

## Requirements
- R1: After reset `irq_o` and `ipl_o` are 0, every mask bit is set (all sources blocked), no pending or in-service bit is set, and the vector base is 0.
- R2: Writes use `wr_sel_i`: 0 replaces the mask with `wr_data_i[15:1]`, 1 clears pending bits, 2 clears in-service bits, and 3 loads the vector base from `wr_data_i[3:0]`. A source whose mask bit is 1 never causes a request. Its pending bit is still latched and takes effect once the mask bit is cleared.
- R3: Among eligible sources (pending, unmasked and not blocked), the highest-numbered one is presented. `vec_o` equals {vector base, 4-bit source number}.
- R4: `irq_o` is registered. A strobe on `evt_i` at clock edge k sets the pending bit at edge k. The request then rises at edge k+1, not before.
- R5: An acknowledge (`iack_i` high while `irq_o` is high) does three things at one edge: it clears the presented source's pending bit, sets its in-service bit, and drops `irq_o` for at least one cycle. The remaining sources are then evaluated again.
- R6: While any in-service bit is set, sources numbered at or below the highest in-service source cannot request. Higher-numbered sources can request and preempt.
- R7: Pending and in-service bits clear only where a 1 is written; bit 0 of the write data has no effect. If an event and a pending clear hit the same source in the same cycle, the pending bit stays set.
- R8: `iack_i` while `irq_o` is low changes no pending or in-service bit.
- R9: `ipl_o` reads 4 while `irq_o` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 15 | One-cycle event strobes, bit i is source i (i = 1..15) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 pending clear, 2 in-service clear, 3 vector base |
| wr_data_i | input | 16 | Write data; source i uses bit i, the vector base uses bits 3:0 |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Registered request level to the processor |
| ipl_o | output | 3 | Processor priority level of the request |
| vec_o | output | 8 | Vector number of the presented source |

## Verification
Internal state shows up at the ports only through the request and the vector. A wrong pending, mask or in-service bit therefore appears as a missing request, an extra request, or the wrong low nibble of `vec_o`, one edge after the state itself changes. A stale in-service bit only becomes visible when a lower source should win after a release, so the stimulus releases nested sources in several orders. Each check reads the ports one full cycle after the stimulus edge, which is where the registered request settles.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    WR_MASK = 2'd0,
    WR_PCLR = 2'd1,
    WR_ICLR = 2'd2,
    WR_BASE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/nic_prio.sv
// Fixed-priority picker: highest set index wins, index 0 unused.
module nic_prio #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N:1]    req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 1; i <= N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nic_block.sv
// Thermometer gate: source i may request only if no in-service bit at i or above.
module nic_block #(
  parameter int N = 15
) (
  input  logic [N:1] isr_i,
  output logic [N:1] allow_o
);
  for (genvar g = 1; g <= N; g++) begin : g_allow
    assign allow_o[g] = ~|isr_i[N:g];
  end
endmodule

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int N   = 15,
  parameter int IW  = 4,
  parameter int VBW = 4,
  parameter int DW  = N + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N:1]     evt_i,
  input  logic           wr_en_i,
  input  wr_sel_e        wr_sel_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           ack_fire_i,
  input  logic [IW-1:0]  ack_idx_i,
  output logic [N:1]     pend_o,
  output logic [N:1]     mask_o,
  output logic [N:1]     isr_o,
  output logic [VBW-1:0] base_o
);
  logic [N:1]     pend_q, pend_d, mask_q, mask_d, isr_q, isr_d;
  logic [VBW-1:0] base_q, base_d;
  logic [N:1]     ack_vec, pclr, iclr;
  logic           mask_en, base_en;

  always_comb begin
    for (int i = 1; i <= N; i++) begin
      ack_vec[i] = ack_fire_i && (ack_idx_i == IW'(i));
    end
    pclr    = (wr_en_i && wr_sel_i == WR_PCLR) ? wr_data_i[N:1] : '0;
    iclr    = (wr_en_i && wr_sel_i == WR_ICLR) ? wr_data_i[N:1] : '0;
    mask_en = wr_en_i && (wr_sel_i == WR_MASK);
    base_en = wr_en_i && (wr_sel_i == WR_BASE);
    pend_d  = (pend_q & ~pclr & ~ack_vec) | evt_i;
    isr_d   = (isr_q & ~iclr) | ack_vec;
    mask_d  = wr_data_i[N:1];
    base_d  = wr_data_i[VBW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign isr_o  = isr_q;
  assign base_o = base_q;
endmodule

// File: rtl/nic_top.sv
module nic_top
  import nic_pkg::*;
#(
  parameter int NSRC  = 15,
  parameter int VBW   = 4,
  parameter int LEVEL = 4,
  parameter int IW    = $clog2(NSRC + 1),
  parameter int DW    = NSRC + 1,
  parameter int VW    = VBW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC:1] evt_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          iack_i,
  output logic          irq_o,
  output logic [2:0]    ipl_o,
  output logic [VW-1:0] vec_o
);
  logic           rst_s1, rst_sync_n;
  logic [NSRC:1]  pend_w, mask_w, isr_w, allow_w, elig;
  logic [VBW-1:0] base_w;
  logic           any_w, irq_q, irq_d, ack_fire;
  logic [IW-1:0]  win_idx, sel_q, sel_d;

  // reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign ack_fire = iack_i & irq_q;

  nic_regs #(.N(NSRC), .IW(IW), .VBW(VBW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt_i      (evt_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_e'(wr_sel_i)),
    .wr_data_i  (wr_data_i),
    .ack_fire_i (ack_fire),
    .ack_idx_i  (sel_q),
    .pend_o     (pend_w),
    .mask_o     (mask_w),
    .isr_o      (isr_w),
    .base_o     (base_w)
  );

  nic_block #(.N(NSRC)) u_block (
    .isr_i   (isr_w),
    .allow_o (allow_w)
  );

  assign elig = pend_w & ~mask_w & allow_w;

  nic_prio #(.N(NSRC), .IW(IW)) u_prio (
    .req_i (elig),
    .any_o (any_w),
    .idx_o (win_idx)
  );

  always_comb begin
    irq_d = any_w & ~ack_fire;
    sel_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
      sel_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (!ack_fire) sel_q <= sel_d;
    end
  end

  assign irq_o = irq_q;
  assign ipl_o = irq_q ? 3'(LEVEL) : 3'd0;
  assign vec_o = {base_w, sel_q};
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int N  = 15,
  parameter int IW = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N:1]    evt_i,
  input logic          iack_i,
  input logic          irq_o,
  input logic [2:0]    ipl_o,
  input logic [VW-1:0] vec_o,
  input logic [N:1]    pend_q,
  input logic [N:1]    isr_q
);
  logic [N:0] isr_pad;
  assign isr_pad = {isr_q, 1'b0};

  AST_IPL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_o == (irq_o ? 3'd4 : 3'd0)); // R9

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && irq_o) |=> !irq_o); // R5

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && irq_o) |=> ((isr_q & ~$past(isr_q)) != '0)); // R5

  AST_IDLE_ACK_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && !irq_o) |=> ((isr_q & ~$past(isr_q)) == '0)); // R8

  AST_NO_BLOCKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((isr_pad >> vec_o[IW-1:0]) == '0)); // R6

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R7
endmodule

bind nic_top nic_chk #(.N(NSRC), .IW(IW), .VW(VW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .evt_i  (evt_i),
  .iack_i (iack_i),
  .irq_o  (irq_o),
  .ipl_o  (ipl_o),
  .vec_o  (vec_o),
  .pend_q (pend_w),
  .isr_q  (isr_w)
);

// File: tb/sim_nic_top.sv
module sim_nic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {evt16, wr, sel2, data16, ack, exp_irq, exp_vec8}
  localparam logic [44:0] VEC [NV] = '{
    {16'h0000, 1'b1, 2'd3, 16'h000A, 1'b0, 1'b0, 8'h00}, // R2 base=A
    {16'h0008, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00}, // R2 src3 masked
    {16'h0000, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hA3}, // R2 unmask, latched src3
    {16'h0020, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hA5}, // R3 src5 wins
    {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h00}, // R5/R6 ack5, 3 blocked
    {16'h0200, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hA9}, // R6 src9 preempts
    {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h00}, // R5 ack9
    {16'h0200, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00}, // R6 equal blocked
    {16'h0000, 1'b1, 2'd2, 16'h0200, 1'b0, 1'b1, 8'hA9}, // R7 release 9
    {16'h0000, 1'b1, 2'd0, 16'h0200, 1'b0, 1'b0, 8'h00}, // R2 mask 9
    {16'h0000, 1'b1, 2'd2, 16'h0020, 1'b0, 1'b1, 8'hA3}, // R6 release 5
    {16'h0000, 1'b1, 2'd1, 16'h0008, 1'b0, 1'b0, 8'h00}, // R7 clear pend3
    {16'h0000, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hA9}, // R2 unmask 9
    {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h00}, // R5 ack9
    {16'h8000, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hAF}, // R6 src15 preempts
    {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h00}, // R5 ack15
    {16'h0000, 1'b1, 2'd2, 16'hFFFF, 1'b0, 1'b0, 8'h00}, // R7 clear all isr
    {16'h0006, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hA2}, // R3 src2 over src1
    {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h00}, // R6 ack2, 1 blocked
    {16'h0000, 1'b1, 2'd2, 16'h0004, 1'b0, 1'b1, 8'hA1}  // R6 release 2
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        iack;
  logic        irq;
  logic [2:0]  ipl;
  logic [7:0]  vec;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt[15:1]), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .iack_i(iack),
    .irq_o(irq), .ipl_o(ipl), .vec_o(vec)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic [15:0] e, input logic w, input logic [1:0] s,
                       input logic [15:0] d, input logic a);
    evt = e; wr_en = w; wr_sel = s; wr_data = d; iack = a;
  endtask

  task automatic idle();
    drive(16'h0, 1'b0, 2'd0, 16'h0, 1'b0);
  endtask

  // apply for one edge, idle for one edge, sample at the following negedge
  task automatic step(input logic [15:0] e, input logic w, input logic [1:0] s,
                      input logic [15:0] d, input logic a);
    drive(e, w, s, d, a);
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    check("R1 ipl after reset", {13'd0, ipl}, 16'd0);
    step(16'h0080, 1'b0, 2'd0, 16'h0, 1'b0);
    check("R1 reset mask blocks", {15'd0, irq}, 16'd0);
    step(16'h0, 1'b1, 2'd1, 16'h0080, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][44:29], VEC[i][28], VEC[i][27:26], VEC[i][25:10], VEC[i][9]);
      check($sformatf("R3 table irq %0d", i), {15'd0, irq}, {15'd0, VEC[i][8]});
      check($sformatf("R9 table ipl %0d", i), {13'd0, ipl}, VEC[i][8] ? 16'd4 : 16'd0);
      if (VEC[i][8]) check($sformatf("R3 table vec %0d", i), {8'd0, vec}, {8'd0, VEC[i][7:0]});
    end

    // R8: ack with no request leaves in-service bits alone
    step(16'h0, 1'b1, 2'd0, 16'hFFFE, 1'b0);
    check("R2 all masked", {15'd0, irq}, 16'd0);
    step(16'h0, 1'b0, 2'd0, 16'h0, 1'b1);
    step(16'h0, 1'b1, 2'd0, 16'h0000, 1'b0);
    check("R8 idle ack ignored irq", {15'd0, irq}, 16'd1);
    check("R8 idle ack ignored vec", {8'd0, vec}, 16'h00A1);

    // R7: event wins over pending clear in the same cycle
    step(16'h0002, 1'b1, 2'd1, 16'h0002, 1'b0);
    check("R7 event beats clear", {15'd0, irq}, 16'd1);
    step(16'h0, 1'b1, 2'd1, 16'h0003, 1'b0);
    check("R7 clear alone", {15'd0, irq}, 16'd0);

    // R4: request latency
    drive(16'h0010, 1'b0, 2'd0, 16'h0, 1'b0);
    @(negedge clk);
    idle();
    check("R4 no request yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R4 request raised", {15'd0, irq}, 16'd1);
    check("R4 vector", {8'd0, vec}, 16'h00A4);
    check("R9 ipl level", {13'd0, ipl}, 16'd4);

    // R5: request low in the cycle after ack, back when another source waits
    step(16'h0040, 1'b0, 2'd0, 16'h0, 1'b0);
    check("R5 src6 presented", {8'd0, vec}, 16'h00A6);
    drive(16'h0, 1'b0, 2'd0, 16'h0, 1'b1);
    @(negedge clk);
    idle();
    check("R5 drop after ack", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R5 src4 still blocked", {15'd0, irq}, 16'd0);
    step(16'h0, 1'b1, 2'd2, 16'h0040, 1'b0);
    check("R5 src4 after release", {8'd0, vec}, 16'h00A4);

    // R1: reset mid-run clears base and pending
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after second reset", {15'd0, irq}, 16'd0);
    step(16'h0, 1'b1, 2'd0, 16'h0000, 1'b0);
    check("R1 pending cleared", {15'd0, irq}, 16'd0);
    step(16'h0010, 1'b0, 2'd0, 16'h0, 1'b0);
    check("R1 base zero", {8'd0, vec}, 16'h0004);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule